// File: doc/BRIEF.md
# Two-Mode Syndrome Sequencer and Error Locator

This block runs a serial parity engine against a stored 256-bit message and then reuses the same hardware to find where a single bit error sits. An 8-bit address counter walks the message store one bit per clock. The selected bit is shifted into an 8-bit Galois-form feedback register built on the primitive polynomial x^8+x^4+x^3+x^2+1. A two-state controller decides when the walk stops. The final register value is the result.

In check mode the whole 256-bit sequence is fed in and the run ends at terminal count. The last eight positions come from the switch word rather than the store. With the switch word at zero the result is the parity byte. With the parity byte on the switches the result is zero for an intact message, or an error syndrome otherwise.

In locate mode an impulse (a single one followed by zeros) is fed in, and the run stops as soon as the register equals the switch word. The frozen counter value then gives the position of the error. Finding the position this way is a timed search, so no syndrome-to-position table is needed.

Top module: `parity_locator`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `lfsr_q` = 0, `count_q` = 0 and `done` = 0, and the controller is in its active state.
- R2: Each enabled shift replaces register value s with {s[6:0], b} XOR (s[7] ? 8'h1D : 8'h00), where b is the current serial bit.
- R3: While active and not stopping, `count_q` rises by exactly one per clock from 0. In the stopping cycle it holds its value.
- R4: With `mode_check` = 1, the serial bit at count a is message bit MSG[a] for a < 248 and `sw[255-a]` for a >= 248. The run shifts 256 bits, ends with `count_q` = 255, and `done` rises on the clock after the cycle with count 255 (256 clocks after reset).
- R5: With `mode_check` = 0, the serial bit is 1 at count 0 and 0 afterwards. In the first cycle where `lfsr_q` equals `sw`, neither the register nor the counter advances, and `done` rises on the next clock. With `sw` = 0 this gives `count_q` = 0 and `done` after one clock.
- R6: Once `done` is high, it stays high and `lfsr_q` and `count_q` stay constant until reset. Changes on `mode_check` or `sw` have no effect.
- R7: If a check run with `sw` = 0 yields P, then a check run with `sw` = P yields `lfsr_q` = 0.
- R8: A single flipped bit at message address a (1..255), checked with `sw` = P, gives the syndrome x^(255-a) mod the polynomial. A locate run with that syndrome on `sw` stops at `count_q` = 256-a, which is the error position counted from the right starting at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, starts a run |
| mode_check | input | 1 | 1 = check mode (full sequence), 0 = locate mode (impulse search) |
| sw | input | 8 | Parity override word in check mode, target syndrome in locate mode |
| lfsr_q | output | 8 | Feedback register value |
| count_q | output | 8 | Address counter value |
| done | output | 1 | High once the run has stopped |

## Verification
The hard situation is a corrupted message, because the store is fixed at elaboration and cannot be written from the ports. The bench therefore elaborates extra copies of the block, each with one message bit flipped at a chosen address. It runs all copies in check mode with the clean parity byte to get their syndromes, then feeds each syndrome back in locate mode to check the reported position. Errors in the last eight positions are reached through the switch word, by flipping single bits of the parity byte. A cycle-level behavioural model of the clean instance is compared on every clock.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_DONE   = 1'b1
  } plc_state_e;

  // Default message contents; address 0 (the first bit shifted) is kept at 0.
  localparam logic [255:0] PLC_DEFAULT_MSG = {
    64'hA5C3_19F0_7E2D_4B86,
    64'h3D91_C07A_E254_6F1B,
    64'h58E2_0BD7_94A6_31CF,
    64'h0F7C_D3A1_6B28_E594
  };

endpackage

// File: rtl/plc_lfsr.sv
module plc_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] state
);

  // One Galois step: shift left, serial bit enters at the bottom,
  // the outgoing top bit folds the tap pattern back in.
  function automatic logic [W-1:0] galois_step(input logic [W-1:0] s, input logic b);
    logic [W-1:0] shifted;
    shifted = {s[W-2:0], b};
    return s[W-1] ? (shifted ^ POLY) : shifted;
  endfunction

  logic [W-1:0] nxt;
  assign nxt = galois_step(state, din);

  always_ff @(posedge clk) begin
    if (rst)     state <= '0;
    else if (en) state <= nxt;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  p_clear_r1: assert property (@(posedge clk)
    rst |=> state == '0);

endmodule

// File: rtl/plc_counter.sv
module plc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         tc
);

  localparam logic [W-1:0] LAST = {W{1'b1}};

  assign tc = (count == LAST);

  always_ff @(posedge clk) begin
    if (rst)     count <= '0;
    else if (en) count <= count + W'(1);
  end

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> count == $past(count) + W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  p_clear_r1: assert property (@(posedge clk)
    rst |=> count == '0);

endmodule

// File: rtl/plc_source.sv
module plc_source #(
  parameter int                 W     = 8,
  parameter int                 DEPTH = 1 << W,
  parameter logic [DEPTH-1:0]   MSG   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addr,
  input  logic         check_mode,
  input  logic [W-1:0] sw,
  output logic         bit_o
);

  localparam int          LW       = $clog2(W);
  localparam int          PAR_BASE = DEPTH - W;
  localparam logic [W-1:0] PB       = W'(PAR_BASE);

  logic         in_parity;
  logic [W-1:0] rev_addr;
  logic         store_bit;
  logic         sw_bit;
  logic         impulse_bit;

  // Position counted back from the last address selects the switch bit.
  assign rev_addr    = ~addr;
  assign in_parity   = (addr >= PB);
  assign store_bit   = MSG[addr];
  assign sw_bit      = sw[rev_addr[LW-1:0]];
  assign impulse_bit = (addr == '0);

  always_comb begin
    if (check_mode) bit_o = in_parity ? sw_bit : store_bit;
    else            bit_o = impulse_bit;
  end

  p_impulse_r5: assert property (@(posedge clk) disable iff (rst)
    (!check_mode && addr != '0) |-> !bit_o);

  p_override_r4: assert property (@(posedge clk) disable iff (rst)
    (check_mode && addr == {W{1'b1}}) |-> bit_o == sw[0]);

endmodule

// File: rtl/plc_control.sv
module plc_control
  import plc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic check_mode,
  input  logic tc,
  input  logic match,
  output logic lfsr_en,
  output logic cnt_en,
  output logic done
);

  plc_state_e st;
  logic       active;
  logic       hit;
  logic       stop;

  assign active = (st == ST_ACTIVE);
  // Locate mode: an equal register must not shift any further.
  assign hit    = !check_mode && match;
  assign stop   = active && (tc || hit);

  assign lfsr_en = active && !hit;
  assign cnt_en  = active && !stop;
  assign done    = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst)       st <= ST_ACTIVE;
    else if (stop) st <= ST_DONE;
  end

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!lfsr_en && !cnt_en));

  p_tc_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (active && check_mode && tc) |=> done);

  p_match_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (active && hit) |=> done);

  p_reset_active_r1: assert property (@(posedge clk)
    rst |=> !done);

endmodule

// File: rtl/parity_locator.sv
module parity_locator #(
  parameter int                        W     = 8,
  parameter logic [W-1:0]              POLY  = 8'h1D,
  parameter logic [(1 << W)-1:0]       MSG   = plc_pkg::PLC_DEFAULT_MSG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_check,
  input  logic [W-1:0] sw,
  output logic [W-1:0] lfsr_q,
  output logic [W-1:0] count_q,
  output logic         done
);

  localparam int DEPTH = 1 << W;

  logic         tc;
  logic         match;
  logic         lfsr_en;
  logic         cnt_en;
  logic         serial_bit;

  assign match = (lfsr_q == sw);

  plc_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (cnt_en),
    .count (count_q),
    .tc    (tc)
  );

  plc_source #(.W(W), .DEPTH(DEPTH), .MSG(MSG)) u_src (
    .clk        (clk),
    .rst        (rst),
    .addr       (count_q),
    .check_mode (mode_check),
    .sw         (sw),
    .bit_o      (serial_bit)
  );

  plc_lfsr #(.W(W), .POLY(POLY)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .en    (lfsr_en),
    .din   (serial_bit),
    .state (lfsr_q)
  );

  plc_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .check_mode (mode_check),
    .tc         (tc),
    .match      (match),
    .lfsr_en    (lfsr_en),
    .cnt_en     (cnt_en),
    .done       (done)
  );

  p_locate_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (!done && !mode_check && match) |=> ($stable(lfsr_q) && $stable(count_q)));

endmodule

// File: tb/test_parity_locator.sv
`timescale 1ns/1ps
module test_parity_locator;

  localparam logic [255:0] BASE = {
    64'hA5C3_19F0_7E2D_4B86, 64'h3D91_C07A_E254_6F1B,
    64'h58E2_0BD7_94A6_31CF, 64'h0F7C_D3A1_6B28_E594
  };
  localparam int NE = 8;

  function automatic int err_addr(input int g);
    case (g)
      0: return 1;    1: return 2;    2: return 7;    3: return 64;
      4: return 100;  5: return 200;  6: return 246;  default: return 247;
    endcase
  endfunction

  logic       clk = 0;
  logic       rst = 1;
  logic       mode_check = 1;
  logic [7:0] sw = 0;
  logic [7:0] lfsr_q, count_q;
  logic       done;

  logic [7:0] sw_e  [NE];
  logic [7:0] lf_e  [NE];
  logic [7:0] cnt_e [NE];
  logic       dn_e  [NE];

  always #2 clk = ~clk;

  parity_locator #(.MSG(BASE)) i_parity_locator (
    .clk(clk), .rst(rst), .mode_check(mode_check), .sw(sw),
    .lfsr_q(lfsr_q), .count_q(count_q), .done(done));

  for (genvar g = 0; g < NE; g++) begin : g_err
    parity_locator #(.MSG(BASE ^ (256'(1) << err_addr(g)))) i_parity_locator (
      .clk(clk), .rst(rst), .mode_check(mode_check), .sw(sw_e[g]),
      .lfsr_q(lf_e[g]), .count_q(cnt_e[g]), .done(dn_e[g]));
  end

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // x^n reduced by x^8+x^4+x^3+x^2+1, by plain integer arithmetic
  function automatic int xpow(input int n);
    int r = 1;
    for (int i = 0; i < n; i++) begin
      r = r * 2;
      if (r >= 256) r = r ^ 'h11D;
    end
    return r;
  endfunction

  function automatic int syn_of(input logic [255:0] m, input int swv);
    int s = swv;
    for (int a = 0; a < 248; a++) if (m[a]) s = s ^ xpow(255 - a);
    return s;
  endfunction

  // Behavioural reference of the clean instance, advanced on every edge
  int rs, rc, rd;
  bit ref_ok = 0;
  always @(posedge clk) begin
    if (rst) begin
      rs = 0; rc = 0; rd = 0; ref_ok = 1;
    end else if (ref_ok && rd == 0) begin
      int b;
      if (mode_check) b = (rc >= 248) ? int'(sw[255 - rc]) : int'(BASE[rc]);
      else            b = (rc == 0) ? 1 : 0;
      if (!mode_check && rs == int'(sw)) rd = 1;
      else begin
        rs = rs * 2 + b;
        if (rs >= 256) rs = rs ^ 'h11D;
        if (rc == 255) rd = 1; else rc = rc + 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (ref_ok && !rst) begin
      chk("R2", lfsr_q, rs, "ref register");
      chk("R3", count_q, rc, "ref count");
      chk("R6", done, rd, "ref done");
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic start(input logic m, input logic [7:0] s);
    @(negedge clk);
    rst = 1; mode_check = m; sw = s;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  int parity, lf0, c0;

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    chk("R1", lfsr_q, 0, "reset register");
    chk("R1", count_q, 0, "reset count");
    chk("R1", done, 0, "reset done");

    // R4 parity run, done exactly 256 clocks after reset
    for (int g = 0; g < NE; g++) sw_e[g] = 0;
    start(1, 0);
    wait_cycles(255);
    chk("R4", done, 0, "done before 256th edge");
    wait_cycles(1);
    chk("R4", done, 1, "done after 256 edges");
    chk("R4", count_q, 255, "final count");
    parity = syn_of(BASE, 0);
    chk("R4", lfsr_q, parity, "parity byte");
    parity = lfsr_q;

    // R6 freeze, mode and switch changes ignored
    lf0 = lfsr_q; c0 = count_q;
    mode_check = 0; sw = 8'h5A;
    wait_cycles(6);
    chk("R6", lfsr_q, lf0, "register frozen");
    chk("R6", count_q, c0, "count frozen");
    chk("R6", done, 1, "done sticky");

    // R7 parity cancels; R8 syndromes of injected errors
    for (int g = 0; g < NE; g++) sw_e[g] = parity[7:0];
    start(1, parity[7:0]);
    wait_cycles(260);
    chk("R7", lfsr_q, 0, "clean message with parity");
    for (int g = 0; g < NE; g++)
      chk("R8", lf_e[g], xpow(255 - err_addr(g)), $sformatf("syndrome addr %0d", err_addr(g)));

    // R8 locate each stored error
    for (int g = 0; g < NE; g++) sw_e[g] = lf_e[g];
    start(0, 8'h00);
    wait_cycles(260);
    for (int g = 0; g < NE; g++) begin
      chk("R8", cnt_e[g], 256 - err_addr(g), $sformatf("position addr %0d", err_addr(g)));
      chk("R5", lf_e[g], int'(sw_e[g]), "stopped on match");
    end

    // R5 zero target stops at once
    chk("R5", count_q, 0, "zero target count");
    chk("R5", done, 1, "zero target done");

    // R8 errors in the parity positions, reached by flipping switch bits
    for (int i = 0; i < 8; i += 7) begin
      start(1, parity[7:0] ^ 8'(1 << i));
      wait_cycles(260);
      chk("R8", lfsr_q, 1 << i, $sformatf("parity-bit syndrome %0d", i));
      start(0, 8'(1 << i));
      wait_cycles(260);
      chk("R8", count_q, i + 1, $sformatf("parity-bit position %0d", i));
    end

    // R5 locate with a mid-range target
    start(0, 8'(xpow(99)));
    wait_cycles(260);
    chk("R5", count_q, 100, "mid target count");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule